// File: doc/BRIEF.md
# DRAM Page Idle-Close Timer

This block keeps a record of which DRAM pages are open, one flag per bank in every row, and asks for all of them to be closed once the memory has been idle for a programmed number of clocks. Each access strobe names a row and a bank, and that page's flag is set. An idle indication from the controller lets the idle count advance. A 4-bit idle code picks the timeout from a fixed non-linear set of values, or turns closing on idleness off altogether.

An 8-bit field holds one bit per row. It says whether that row is built from two or four internal banks. On a two-bank row, any bank index is reduced to its low bit. The close request stays high until the controller acknowledges it. At that point every open-page flag is cleared. The precharge itself, and arbitration against refresh, are left to the surrounding controller.

Top module: `page_idle_closer`

## Requirements
- R1: After a synchronous active-low reset, `open_map` is all zero and `close_req` is low.
- R2: An access with `bank4_mask[row]`=1 sets `open_map` bit `row*4+bank` on the clock edge that captures it; other bits keep their value.
- R3: An access to a row whose `bank4_mask` bit is 0 sets bit `row*4+bank[0]`, so bank 2 lands on bank 0 and bank 3 on bank 1; bits `row*4+2` and `row*4+3` are never set.
- R4: A counting cycle has `idle`=1, no access, at least one open page and no pending request. With `idle_code` bit 3 clear, the low three bits map 0,1,2,3,4,5,6,7 to limits 0,2,4,8,10,12,16,32. `close_req` goes high after limit+1 consecutive counting cycles following the last access.
- R5: With code 0000, `close_req` goes high on the edge of the first counting cycle after an access.
- R6: With `idle_code` bit 3 set, `close_req` never rises.
- R7: Cycles with `idle`=0 and no access neither advance nor restart the count.
- R8: An access restarts the count from zero.
- R9: `close_req` stays high until sampled with `close_ack`=1. That edge lowers it, clears the count and clears every flag, except the flag of an access taken on the same edge.
- R10: With no page open, the count does not advance and `close_req` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_row | input | 3 | Row of the access |
| acc_bank | input | 2 | Bank of the access |
| idle | input | 1 | Controller idle indication |
| idle_code | input | 4 | Idle timeout code; bit 3 set means never close |
| bank4_mask | input | 8 | Per-row bank count; bit r=1 means row r has 4 banks |
| close_ack | input | 1 | Acknowledge of the close request |
| close_req | output | 1 | Request to precharge all open pages |
| open_map | output | 32 | Open-page flags, bit row*4+bank |

## Verification
The timeout is measured for all eight finite codes by counting idle cycles from an access to the request. This tells a wrong entry in the code map apart from an off-by-one in the compare. Further directed runs do the following:
- break the idle run with non-idle cycles, which shows the difference between holding the count and resetting it;
- break the idle run with a new access, which must restart the count;
- access banks 2 and 3 on two-bank and four-bank rows, which separates folding from direct indexing.

Random traffic then mixes masks, codes, accesses, idle cycles and acknowledges. It compares every cycle against a bench model, which exposes mistakes in the priority between access, acknowledge and count.

// File: rtl/pic_pkg.sv
// Shared definitions for the page idle-close timer.
// Assumes the idle code's low three bits select one of eight timeouts.
package pic_pkg;
    localparam int unsigned LIMIT_MAX = 32;

    // Map the low three bits of the idle code to a timeout in clocks.
    function automatic int unsigned idle_limit(input logic [2:0] sel);
        case (sel)
            3'd0: return 0;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd4: return 10;
            3'd5: return 12;
            3'd6: return 16;
            default: return LIMIT_MAX;
        endcase
    endfunction
endpackage

// File: rtl/pic_limit_dec.sv
// Decodes the 4-bit idle code into a count limit and a never-close flag.
// Assumes CNT_W is wide enough to hold the largest limit.
module pic_limit_dec #(
    parameter int CNT_W = 6
) (
    input  logic [3:0]       code,
    output logic [CNT_W-1:0] limit,
    output logic             never
);
    import pic_pkg::*;

    // Translate the code into a limit; the top bit disables closing.
    always_comb begin
        limit = CNT_W'(idle_limit(code[2:0]));
        never = code[3];
    end
endmodule

// File: rtl/pic_page_flags.sv
// Holds one open flag per bank per row and folds bank indices on two-bank rows.
// Assumes the controller only clears flags through an acknowledged close.
module pic_page_flags #(
    parameter int ROWS   = 8,
    parameter int BANKS  = 4,
    parameter int ROW_W  = 3,
    parameter int BANK_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic [ROW_W-1:0]       acc_row,
    input  logic [BANK_W-1:0]      acc_bank,
    input  logic [ROWS-1:0]        bank4_mask,
    input  logic                   clear,
    output logic [ROWS*BANKS-1:0]  open_map,
    output logic                   any_open
);
    logic [BANK_W-1:0] eff_bank;

    // Reduce the bank index to its low bit on a two-bank row.
    always_comb begin
        if (bank4_mask[acc_row]) eff_bank = acc_bank;
        else                     eff_bank = BANK_W'(acc_bank[0]);
    end

    // Summarise whether any page is open.
    always_comb any_open = |open_map;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic hit;
            // Decode whether this access opens the page of this row and bank.
            always_comb hit = acc_valid && (acc_row == ROW_W'(r)) && (eff_bank == BANK_W'(b));
            // Set the flag on an access; clear it on an acknowledged close.
            always_ff @(posedge clk) begin
                if (!rst_n)     open_map[r*BANKS+b] <= 1'b0;
                else if (hit)   open_map[r*BANKS+b] <= 1'b1;
                else if (clear) open_map[r*BANKS+b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pic_idle_counter.sv
// Counts idle cycles since the last access and raises a held close request.
// Assumes idle cycles count only while a page is open and no request pends.
module pic_idle_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             idle,
    input  logic             any_open,
    input  logic [CNT_W-1:0] limit,
    input  logic             never,
    input  logic             close_ack,
    output logic             close_req
);
    logic [CNT_W-1:0] cnt;
    logic             counting;

    // A counting cycle is idle, with no access, something open and nothing pending.
    always_comb counting = idle && !acc_valid && any_open && !close_req && !never;

    // Advance the count, raise the request at the limit, drop it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            close_req <= 1'b0;
        end else if (close_req && close_ack) begin
            cnt       <= '0;
            close_req <= 1'b0;
        end else if (acc_valid) begin
            cnt <= '0;
        end else if (counting) begin
            if (cnt >= limit) close_req <= 1'b1;
            else              cnt       <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/page_idle_closer.sv
// Top of the page idle-close timer: open-page tracking plus idle timeout.
// Assumes accesses, idle and acknowledge are synchronous to clk.
module page_idle_closer #(
    parameter int ROWS   = 8,
    parameter int BANKS  = 4,
    parameter int ROW_W  = $clog2(ROWS),
    parameter int BANK_W = $clog2(BANKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic [ROW_W-1:0]      acc_row,
    input  logic [BANK_W-1:0]     acc_bank,
    input  logic                  idle,
    input  logic [3:0]            idle_code,
    input  logic [ROWS-1:0]       bank4_mask,
    input  logic                  close_ack,
    output logic                  close_req,
    output logic [ROWS*BANKS-1:0] open_map
);
    localparam int CNT_W = $clog2(pic_pkg::LIMIT_MAX + 1);

    logic [CNT_W-1:0] limit;
    logic             never;
    logic             any_open;
    logic             clear;

    // An acknowledged request clears the page flags.
    always_comb clear = close_req && close_ack;

    pic_limit_dec #(.CNT_W(CNT_W)) u_dec (
        .code  (idle_code),
        .limit (limit),
        .never (never)
    );

    pic_page_flags #(.ROWS(ROWS), .BANKS(BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_row    (acc_row),
        .acc_bank   (acc_bank),
        .bank4_mask (bank4_mask),
        .clear      (clear),
        .open_map   (open_map),
        .any_open   (any_open)
    );

    pic_idle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .idle      (idle),
        .any_open  (any_open),
        .limit     (limit),
        .never     (never),
        .close_ack (close_ack),
        .close_req (close_req)
    );
endmodule

// File: rtl/pic_checker.sv
// Property checks for the page idle-close timer, bound to its top.
module pic_checker #(
    parameter int ROWS   = 8,
    parameter int BANKS  = 4,
    parameter int ROW_W  = 3,
    parameter int BANK_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_valid,
    input logic [ROW_W-1:0]      acc_row,
    input logic [BANK_W-1:0]     acc_bank,
    input logic                  idle,
    input logic [3:0]            idle_code,
    input logic [ROWS-1:0]       bank4_mask,
    input logic                  close_ack,
    input logic                  close_req,
    input logic [ROWS*BANKS-1:0] open_map
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (open_map == '0 && !close_req));

    assert_never_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(close_req) |-> !$past(idle_code[3]));

    assert_rise_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(close_req) |-> $past(idle && !acc_valid));

    assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(close_req) |-> $past(close_ack));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (close_req && close_ack && !acc_valid) |=> (open_map == '0));

    assert_empty_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(close_req) |-> ($past(open_map) != '0));
endmodule

bind page_idle_closer pic_checker #(.ROWS(ROWS), .BANKS(BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_row(acc_row), .acc_bank(acc_bank),
    .idle(idle), .idle_code(idle_code), .bank4_mask(bank4_mask), .close_ack(close_ack),
    .close_req(close_req), .open_map(open_map)
);

// File: tb/sim_page_idle_closer.sv
module sim_page_idle_closer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_row = '0;
    logic [1:0]  acc_bank = '0;
    logic        idle = 1'b0;
    logic [3:0]  idle_code = '0;
    logic [7:0]  bank4_mask = '0;
    logic        close_ack = 1'b0;
    logic        close_req;
    logic [31:0] open_map;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    logic [31:0] m_map = '0;
    int    m_cnt = 0;
    bit    m_req = 1'b0;

    always #5 clk = ~clk;

    page_idle_closer u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_row(acc_row), .acc_bank(acc_bank),
        .idle(idle), .idle_code(idle_code), .bank4_mask(bank4_mask), .close_ack(close_ack),
        .close_req(close_req), .open_map(open_map)
    );

    function automatic int lim_of(input logic [2:0] c);
        int t[8] = '{0, 2, 4, 8, 10, 12, 16, 32};
        return t[c];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance the reference model by the inputs now applied, then compare after the edge.
    task automatic tick();
        logic [31:0] nmap;
        bit          open;
        open = (m_map != 0);
        nmap = (m_req && close_ack) ? 32'h0 : m_map;
        if (!rst_n) begin
            m_map = '0; m_cnt = 0; m_req = 0;
        end else begin
            if (acc_valid)
                nmap[acc_row*4 + (bank4_mask[acc_row] ? acc_bank : {1'b0, acc_bank[0]})] = 1'b1;
            if (m_req && close_ack) begin
                m_req = 0; m_cnt = 0;
            end else if (acc_valid) begin
                m_cnt = 0;
            end else if (idle && open && !m_req && !idle_code[3]) begin
                if (m_cnt >= lim_of(idle_code[2:0])) m_req = 1;
                else m_cnt++;
            end
            m_map = nmap;
        end
        @(negedge clk);
        check("R2/R4 model open_map", open_map, m_map);
        check("R4/R9 model close_req", {31'b0, close_req}, {31'b0, m_req});
    endtask

    task automatic access(input int r, input int b);
        acc_valid = 1; acc_row = 3'(r); acc_bank = 2'(b); idle = 0;
        tick();
        acc_valid = 0;
    endtask

    task automatic drain();
        close_ack = 1; tick(); close_ack = 0;
    endtask

    // Count idle cycles from now until the request rises, at most max_n.
    task automatic idle_until_req(input int max_n, output int n);
        n = 0; idle = 1;
        while (!close_req && n < max_n) begin tick(); n++; end
        idle = 0;
    endtask

    initial begin
        int n;
        void'($urandom(32'h1d1e));
        repeat (3) tick();
        check("R1 reset open_map", open_map, 32'h0);
        check("R1 reset close_req", {31'b0, close_req}, 32'h0);
        rst_n = 1; tick();

        // R2/R3: bank folding
        bank4_mask = 8'b0010_0000; idle_code = 4'b1000;
        access(3, 2); check("R3 fold bank2", open_map, 32'h1 << 12);
        access(3, 3); check("R3 fold bank3", open_map, (32'h1 << 12) | (32'h1 << 13));
        access(5, 3); check("R2 four-bank", open_map, (32'h3 << 12) | (32'h1 << 23));
        idle_code = 4'b0000; idle_until_req(5, n); drain();
        check("R9 cleared after ack", open_map, 32'h0);

        // R4/R5: timeout per code
        bank4_mask = 8'hff;
        for (int c = 0; c < 8; c++) begin
            idle_code = 4'(c);
            access(0, 0);
            idle_until_req(40, n);
            check(c == 0 ? "R5 code0 timing" : "R4 code timing", 32'(n), 32'(lim_of(3'(c)) + 1));
            drain();
        end

        // R6: infinite
        idle_code = 4'b1011; access(2, 1);
        idle_until_req(60, n);
        check("R6 never closes", {31'b0, close_req}, 32'h0);

        // R7: non-idle cycles hold the count
        idle_code = 4'd2; access(1, 1);
        idle = 1; repeat (2) tick(); idle = 0; repeat (10) tick();
        idle_until_req(20, n);
        check("R7 idle-low hold", 32'(n), 32'd3);
        drain();

        // R8: access restarts
        idle_code = 4'd3; access(4, 0);
        idle = 1; repeat (6) tick();
        access(4, 1);
        idle_until_req(20, n);
        check("R8 restart", 32'(n), 32'd9);

        // R9: hold until ack, ack with same-cycle access
        repeat (5) tick();
        check("R9 held", {31'b0, close_req}, 32'h1);
        close_ack = 1; acc_valid = 1; acc_row = 3'd1; acc_bank = 2'd1; tick();
        close_ack = 0; acc_valid = 0;
        check("R9 ack keeps new flag", open_map, 32'h1 << 5);
        check("R9 req dropped", {31'b0, close_req}, 32'h0);
        idle_code = 4'd0; idle_until_req(5, n); drain();

        // R10: nothing open
        idle = 1; repeat (40) tick(); idle = 0;
        check("R10 no req when empty", {31'b0, close_req}, 32'h0);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) begin
                bank4_mask = 8'($urandom);
                idle_code = ($urandom % 6 == 0) ? 4'(8 + $urandom % 8) : 4'($urandom % 8);
            end
            acc_valid = ($urandom % 10) == 0;
            acc_row = 3'($urandom); acc_bank = 2'($urandom);
            idle = ($urandom % 5) != 0;
            close_ack = m_req && ($urandom % 3 == 0);
            tick();
        end
        acc_valid = 0; close_ack = 0; idle = 0;
        rst_n = 0; tick();
        check("R1 reset after traffic", open_map, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule